// File: doc/BRIEF.md
# Sequence-Free Stripe Reassembler

This block is the receiving end of a link that spreads fixed-size cells over several parallel channels in strict round-robin order without giving them sequence numbers. Each channel writes into its own small FIFO. One rotating selector takes cells only from the channel it points at. Cells that arrive early on a faster channel stay in their FIFO until the selector reaches that channel. This puts the sender's order back together at the single output, however skewed the channels are.

If a cell is lost, the rotation at the two ends falls out of step. To recover, the receiver keeps a round counter for each channel. The sender now and then sends a marker cell on a channel that carries its own round count for that channel. When a marker reaches the head of the selected FIFO, the receiver compares the two counts and then does one of four things: skip the channel, drop the marker and move on, drop the marker and stay, or report that both ends must start again. A full FIFO holds off its channel's input, so no cell is dropped.

Top module: `stripe_reasm`

## Requirements
- R1: While reset is held, and just after it, `outValid` and `reinitReq` are 0 and every bit of `inReady` is 1. The selector starts on channel 0.
- R2: Cells leave in strict rotation: channel 0, 1, …, NUM_CH-1, then 0 again. The selector moves to the next channel after each data cell is taken (`outValid && outReady`). This restores the sending order however skewed the channels are.
- R3: A cell buffered on a channel the selector does not point at is never presented at the output, even if the selected channel is empty.
- R4: Each channel keeps a ROUND_W-bit round counter that counts the selector's arrivals on that channel and wraps modulo 2^ROUND_W. At reset every counter is 0, but the selector's initial place on channel 0 counts as an arrival, so channel 0 starts at 1. The round of the selected channel is the round expected for its next data cell.
- R5: An input with `inMarker`=1 is a marker whose round is `inRound`, and its `inData` is ignored. Markers go through the FIFO in order with the data cells and never appear at the output. For data cells, `inRound` is ignored.
- R6: A marker at the head of the selected FIFO is compared using d = (marker round − channel round) mod 2^ROUND_W, read as a signed ROUND_W-bit value. If d > 0, the marker stays in the FIFO and the selector moves to the next channel.
- R7: If d = 0, the marker is removed without output and the selector moves to the next channel.
- R8: If d = −1, the marker is removed without output and the selector stays on the same channel, so its next cell is taken next.
- R9: If d ≤ −2, `reinitReq` rises and stays high until reset, and no further cell is output.
- R10: The comparisons of R6–R9 work across the wrap of the round counters, for example a marker round of 2^ROUND_W−1 against a channel round of 0 counts as d = −1.
- R11: `inReady[c]` is 0 exactly when channel c's FIFO holds FIFO_DEPTH entries. A cell offered while `inReady[c]` is 0 is not taken, and every accepted cell is eventually output (or, for a marker, consumed).
- R12: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | NUM_CH | Per-channel cell strobe |
| inReady | output | NUM_CH | Per-channel room available (0 = FIFO full) |
| inMarker | input | NUM_CH | Per-channel flag: the cell is a marker |
| inRound | input | NUM_CH*ROUND_W | Per-channel marker round, channel c in bits [c*ROUND_W +: ROUND_W] |
| inData | input | NUM_CH*DATA_W | Per-channel cell payload, channel c in bits [c*DATA_W +: DATA_W] |
| outValid | output | 1 | Ordered output cell present |
| outReady | input | 1 | Output consumer accepts the cell |
| outData | output | DATA_W | Ordered output payload |
| reinitReq | output | 1 | Sticky request that both ends reinitialise |

## Verification
The hardest case to reach from the ports is the wrap of the round counters. A marker is only told apart from the normal one-behind case by modular subtraction after 2^ROUND_W rounds. The stimulus sends 45 in-order cells so that channel 0's counter wraps to 0, then sends a marker carrying round 15, and checks that the next cell on channel 0 comes out first. The loss case repeats a classic sequence with the first cell dropped and checks the exact reordered output and the return to order once the marker has been processed. The marker-ahead case checks that the marker stays parked, which shows up as channel 0 staying blocked until the rounds meet.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef struct packed {
    logic pop;        // remove head of selected FIFO
    logic advance;    // move selector to next channel
    logic setReinit;  // latch the reinitialise request
  } ctrlStrobes_t;
endpackage

// File: rtl/stripe_chan_fifo.sv
module stripe_chan_fifo #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             notEmpty,
  output logic             notFull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrIdx, rdIdx;
  logic [CW-1:0]    fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx <= '0;
      rdIdx <= '0;
      fill  <= '0;
    end else begin
      if (wrEn) wrIdx <= (wrIdx == LAST) ? '0 : wrIdx + 1'b1;
      if (rdEn) rdIdx <= (rdIdx == LAST) ? '0 : rdIdx + 1'b1;
      fill <= fill + CW'(wrEn) - CW'(rdEn);
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrData;
  end

  assign rdData   = mem[rdIdx];
  assign notEmpty = (fill != '0);
  assign notFull  = (fill != CW'(DEPTH));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> notFull);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |-> notEmpty);
endmodule

// File: rtl/stripe_datapath.sv
module stripe_datapath
  import stripe_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int DATA_W     = 8,
  parameter int ROUND_W    = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         inValid,
  output logic [NUM_CH-1:0]         inReady,
  input  logic [NUM_CH-1:0]         inMarker,
  input  logic [NUM_CH*ROUND_W-1:0] inRound,
  input  logic [NUM_CH*DATA_W-1:0]  inData,
  input  ctrlStrobes_t              strb,
  output logic                      headValid,
  output logic                      headMarker,
  output logic [ROUND_W-1:0]        headRound,
  output logic [DATA_W-1:0]         headData,
  output logic [ROUND_W-1:0]        curRound
);
  localparam int PTR_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ENTRY_W = 1 + ROUND_W + DATA_W;
  localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NUM_CH - 1);

  logic [PTR_W-1:0]   selPtr, nextPtr;
  logic [ROUND_W-1:0] rxRound [NUM_CH];
  logic [ROUND_W-1:0] nextRound;
  logic [ENTRY_W-1:0] fifoRd [NUM_CH];
  logic [NUM_CH-1:0]  fifoNotEmpty, fifoNotFull;
  logic [ENTRY_W-1:0] headEntry;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic chanWr, chanRd;
    assign chanWr = inValid[c] && fifoNotFull[c];
    assign chanRd = strb.pop && (selPtr == PTR_W'(c));
    stripe_chan_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wrEn     (chanWr),
      .wrData   ({inMarker[c], inRound[c*ROUND_W +: ROUND_W], inData[c*DATA_W +: DATA_W]}),
      .rdEn     (chanRd),
      .rdData   (fifoRd[c]),
      .notEmpty (fifoNotEmpty[c]),
      .notFull  (fifoNotFull[c])
    );
  end

  assign inReady   = fifoNotFull;
  assign nextPtr   = (selPtr == LAST_CH) ? '0 : selPtr + 1'b1;
  assign headEntry = fifoRd[selPtr];
  assign headValid = fifoNotEmpty[selPtr];
  assign headMarker = headEntry[ENTRY_W-1];
  assign headRound  = headEntry[DATA_W +: ROUND_W];
  assign headData   = headEntry[DATA_W-1:0];
  assign curRound   = rxRound[selPtr];
  assign nextRound  = rxRound[nextPtr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selPtr <= '0;
    end else if (strb.advance) begin
      selPtr <= nextPtr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) rxRound[c] <= (c == 0) ? ROUND_W'(1) : '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (strb.advance && nextPtr == PTR_W'(c)) rxRound[c] <= rxRound[c] + 1'b1;
      end
    end
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (selPtr != $past(selPtr)) |-> (selPtr == (($past(selPtr) == LAST_CH) ? '0 : $past(selPtr) + 1'b1)));
  assert_round_bump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.advance |=> (curRound == $past(nextRound) + ROUND_W'(1)));
endmodule

// File: rtl/stripe_control.sv
module stripe_control
  import stripe_pkg::*;
#(
  parameter int ROUND_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               headValid,
  input  logic               headMarker,
  input  logic [ROUND_W-1:0] headRound,
  input  logic [ROUND_W-1:0] curRound,
  input  logic               outReady,
  output ctrlStrobes_t       strb,
  output logic               outValid,
  output logic               reinitReq
);
  typedef enum logic [2:0] {
    ACT_IDLE, ACT_DATA, ACT_AHEAD, ACT_EQUAL, ACT_BEHIND1, ACT_FAULT
  } action_t;

  logic [ROUND_W-1:0] roundDiff;
  action_t            action;
  logic               haltFlag;

  assign roundDiff = headRound - curRound;

  always_comb begin
    action = ACT_IDLE;
    if (!haltFlag && headValid) begin
      if (!headMarker)                 action = ACT_DATA;
      else if (roundDiff == '0)        action = ACT_EQUAL;
      else if (roundDiff == '1)        action = ACT_BEHIND1;
      else if ($signed(roundDiff) > 0) action = ACT_AHEAD;
      else                             action = ACT_FAULT;
    end
  end

  always_comb begin
    strb = '0;
    unique case (action)
      ACT_DATA:    begin strb.pop = outReady; strb.advance = outReady; end
      ACT_AHEAD:   strb.advance = 1'b1;
      ACT_EQUAL:   begin strb.pop = 1'b1; strb.advance = 1'b1; end
      ACT_BEHIND1: strb.pop = 1'b1;
      ACT_FAULT:   strb.setReinit = 1'b1;
      default:     strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) haltFlag <= 1'b0;
    else if (strb.setReinit) haltFlag <= 1'b1;
  end

  assign reinitReq = haltFlag;
  assign outValid  = (action == ACT_DATA);

  assert_reinit_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reinitReq |=> reinitReq);
  assert_behind_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.pop && !strb.advance) |-> (headMarker && !outValid));
endmodule

// File: rtl/stripe_reasm.sv
module stripe_reasm
  import stripe_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int DATA_W     = 8,
  parameter int ROUND_W    = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         inValid,
  output logic [NUM_CH-1:0]         inReady,
  input  logic [NUM_CH-1:0]         inMarker,
  input  logic [NUM_CH*ROUND_W-1:0] inRound,
  input  logic [NUM_CH*DATA_W-1:0]  inData,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [DATA_W-1:0]         outData,
  output logic                      reinitReq
);
  ctrlStrobes_t       strb;
  logic               headValid, headMarker;
  logic [ROUND_W-1:0] headRound, curRound;

  stripe_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ROUND_W(ROUND_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inReady    (inReady),
    .inMarker   (inMarker),
    .inRound    (inRound),
    .inData     (inData),
    .strb       (strb),
    .headValid  (headValid),
    .headMarker (headMarker),
    .headRound  (headRound),
    .headData   (outData),
    .curRound   (curRound)
  );

  stripe_control #(.ROUND_W(ROUND_W)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .headValid  (headValid),
    .headMarker (headMarker),
    .headRound  (headRound),
    .curRound   (curRound),
    .outReady   (outReady),
    .strb       (strb),
    .outValid   (outValid),
    .reinitReq  (reinitReq)
  );

  assert_hold_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: tb/test_stripe_reasm.sv
module test_stripe_reasm;
  localparam int K = 3;
  localparam int W = 4;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [K-1:0] inValid = '0;
  logic [K-1:0] inReady;
  logic [K-1:0] inMarker = '0;
  logic [K*W-1:0] inRound = '0;
  logic [K*D-1:0] inData = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [D-1:0] outData;
  logic         reinitReq;

  always #2 clk = ~clk;

  stripe_reasm #(.NUM_CH(K), .DATA_W(D), .ROUND_W(W), .FIFO_DEPTH(4)) i_stripe_reasm (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inMarker(inMarker),
    .inRound(inRound), .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .reinitReq(reinitReq)
  );

  // Loss-recovery table: {channel[1:0], marker, round[3:0], data[7:0]}; first cell (ch0) lost.
  localparam logic [14:0] LOSS_PUSH [0:8] = '{
    {2'd1, 1'b0, 4'd0, 8'h0B}, {2'd2, 1'b0, 4'd0, 8'h0C}, {2'd0, 1'b0, 4'd0, 8'h0D},
    {2'd0, 1'b1, 4'd2, 8'h00}, {2'd1, 1'b0, 4'd0, 8'h0E}, {2'd2, 1'b0, 4'd0, 8'h0F},
    {2'd0, 1'b0, 4'd0, 8'h10}, {2'd1, 1'b0, 4'd0, 8'h11}, {2'd2, 1'b0, 4'd0, 8'h12}};
  localparam logic [7:0] LOSS_EXP [0:7] = '{8'h0D, 8'h0B, 8'h0C, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12};

  int nChecks = 0;
  int nFail = 0;
  int gotCnt = 0;
  int base = 0;
  logic [D-1:0] got [0:255];
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && outValid && outReady) begin
      got[gotCnt] = outData;
      gotCnt = gotCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input int idx, input logic [7:0] e);
    chk(req, (gotCnt > base + idx) ? 32'(got[base + idx]) : 32'hDEAD, 32'(e));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    inValid = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    base = gotCnt;
  endtask

  task automatic push(input int ch, input bit mk, input logic [3:0] rnd, input logic [7:0] dat);
    @(negedge clk);
    inValid = '0;
    inValid[ch] = 1'b1;
    inMarker[ch] = mk;
    inRound[ch*W +: W] = rnd;
    inData[ch*D +: D] = dat;
    while (!inReady[ch]) @(negedge clk);
    @(posedge clk);
    #1 inValid = '0;
  endtask

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    idle(2);
    chk("R1 outValid in reset", 32'(outValid), 0);
    chk("R1 reinitReq in reset", 32'(reinitReq), 0);
    chk("R1 inReady in reset", 32'(inReady), 32'h7);
    rst_n = 1'b1;
    idle(1);
    base = gotCnt;
    chk("R1 outValid after reset", 32'(outValid), 0);

    // R2/R3: skewed arrival, later channels first
    push(2, 0, 0, 8'h0C);
    push(1, 0, 0, 8'h0B);
    idle(3);
    chk("R3 no output while ch0 empty", 32'(outValid), 0);
    chk("R3 nothing taken early", 32'(gotCnt - base), 0);
    push(0, 0, 0, 8'h0A);
    push(0, 0, 0, 8'h0D);
    push(2, 0, 0, 8'h0F);
    push(1, 0, 0, 8'h0E);
    idle(8);
    expectOut("R2 order 0", 0, 8'h0A);
    expectOut("R2 order 1", 1, 8'h0B);
    expectOut("R2 order 2", 2, 8'h0C);
    expectOut("R2 order 3", 3, 8'h0D);
    expectOut("R2 order 4", 4, 8'h0E);
    expectOut("R2 order 5", 5, 8'h0F);
    // R8: marker one round behind, selector stays
    push(0, 1, 4'd2, 8'hEE);
    push(0, 0, 0, 8'h10);
    push(1, 0, 0, 8'h11);
    push(2, 0, 0, 8'h12);
    idle(8);
    expectOut("R8 cell after marker", 6, 8'h10);
    expectOut("R8 order", 7, 8'h11);
    expectOut("R8 order", 8, 8'h12);
    chk("R5 marker not output", 32'(gotCnt - base), 9);
    chk("R8 no reinit", 32'(reinitReq), 0);

    // R7: loss recovery table
    doReset();
    for (int i = 0; i < 9; i++)
      push(int'(LOSS_PUSH[i][14:13]), LOSS_PUSH[i][12], LOSS_PUSH[i][11:8], LOSS_PUSH[i][7:0]);
    idle(10);
    for (int i = 0; i < 8; i++) expectOut("R7 loss recovery", i, LOSS_EXP[i]);
    chk("R7 count", 32'(gotCnt - base), 8);
    chk("R7 no reinit", 32'(reinitReq), 0);

    // R6: marker ahead stays parked
    doReset();
    push(0, 1, 4'd3, 8'h99);
    idle(3);
    chk("R6 marker not output", 32'(outValid), 0);
    push(1, 0, 0, 8'h31);
    push(2, 0, 0, 8'h32);
    push(1, 0, 0, 8'h33);
    push(2, 0, 0, 8'h34);
    push(1, 0, 0, 8'h35);
    push(2, 0, 0, 8'h36);
    push(0, 0, 0, 8'h37);
    idle(8);
    expectOut("R6 skip 0", 0, 8'h31);
    expectOut("R6 skip 1", 1, 8'h32);
    expectOut("R6 skip 2", 2, 8'h33);
    expectOut("R6 skip 3", 3, 8'h34);
    expectOut("R7 after equal", 4, 8'h35);
    expectOut("R7 after equal", 5, 8'h36);
    expectOut("R6 ch0 released", 6, 8'h37);
    chk("R6 no reinit", 32'(reinitReq), 0);

    // R10: round counter wrap
    doReset();
    for (int i = 0; i < 45; i++) push(i % 3, 0, 0, 8'(i));
    idle(5);
    for (int i = 0; i < 45; i++) expectOut("R10 warmup order", i, 8'(i));
    push(0, 1, 4'd15, 8'h00);
    push(0, 0, 0, 8'h64);
    push(1, 0, 0, 8'h65);
    push(2, 0, 0, 8'h66);
    idle(6);
    expectOut("R10 wrap one-behind", 45, 8'h64);
    expectOut("R10 wrap order", 46, 8'h65);
    expectOut("R10 wrap order", 47, 8'h66);
    chk("R10 no reinit", 32'(reinitReq), 0);

    // R11/R12: backpressure and output hold
    doReset();
    outReady = 1'b0;
    push(0, 0, 0, 8'h50);
    idle(3);
    chk("R12 outValid held", 32'(outValid), 1);
    chk("R12 outData held", 32'(outData), 32'h50);
    for (int i = 0; i < 4; i++) push(1, 0, 0, 8'hC0 + 8'(i));
    @(negedge clk);
    chk("R11 full channel not ready", 32'(inReady[1]), 0);
    chk("R11 other channel ready", 32'(inReady[2]), 1);
    outReady = 1'b1;
    for (int i = 0; i < 4; i++) push(2, 0, 0, 8'hA0 + 8'(i));
    for (int i = 1; i < 4; i++) push(0, 0, 0, 8'hB0 + 8'(i));
    idle(10);
    for (int i = 0; i < 4; i++) begin
      expectOut("R11 no drop", 3*i,     (i == 0) ? 8'h50 : 8'hB0 + 8'(i));
      expectOut("R11 no drop", 3*i + 1, 8'hC0 + 8'(i));
      expectOut("R11 no drop", 3*i + 2, 8'hA0 + 8'(i));
    end

    // R9: marker far behind
    doReset();
    for (int i = 0; i < 6; i++) push(i % 3, 0, 0, 8'h20 + 8'(i));
    idle(4);
    push(0, 1, 4'd0, 8'h00);
    idle(3);
    chk("R9 reinit raised", 32'(reinitReq), 1);
    push(0, 0, 0, 8'h77);
    idle(4);
    chk("R9 halted output", 32'(outValid), 0);
    chk("R9 count", 32'(gotCnt - base), 6);
    chk("R9 reinit held", 32'(reinitReq), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule